// File: doc/BRIEF.md
# Burst Latency Configuration and Ready Handshake

This block sits in the control path of a burst-read memory. It watches the host's write cycles for a short protected command: two fixed key writes followed by a third write whose address carries a new initial-latency setting. Only a complete and correctly ordered sequence can change the stored latency. A half-finished sequence can be cancelled with an abort write.

Each time the host latches a new burst address, the block counts the stored number of clock cycles and then raises a ready handshake. Ready does not rise until output enable is low, so the host can watch for the ready rising edge to learn when the first data word is on the bus. A one-cycle first-data pulse marks the same edge for the data path.

Top module: `burst_latency_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wait_total` is 7, `rdy` is 1 and `first_valid` is 0.
- R2: Three writes in a row update `wait_total` to the code N on the clock edge that takes the third write. The writes are: data AAh at address bits [11:0] = 555h, then data 55h at [11:0] = 2AAh, then any data except F0h at [11:0] = 555h with N in address bits [16:12].
- R3: A third-cycle code outside 2..7 (for example 0, 1, 8 or 31) leaves `wait_total` unchanged.
- R4: The sequence restarts from the first key write if a write has the wrong data, the wrong address, or the wrong order. A third write whose bits [11:0] differ from 555h changes nothing.
- R5: A write with data F0h cancels a partial sequence in any state. This holds even on the third cycle with a valid address and code, and `wait_total` keeps its value.
- R6: When `lat_n` is sampled low, `rdy` goes low on that edge. With `oe_n` low, `rdy` rises exactly `wait_total` clock edges after the latch edge.
- R7: If `oe_n` is high when the count expires, `rdy` stays low. It rises on the first edge at which `oe_n` is sampled low.
- R8: `first_valid` is high for exactly the one cycle in which `rdy` rises. After that, `rdy` stays high until the next latch.
- R9: A latch while a count is running restarts the full count from that edge.
- R10: If a latch and a configuration commit fall on the same edge, that count uses the previous `wait_total`. The next latch uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 17 | Write address; [16:12] carry the code on the third write |
| wr_data | input | 8 | Write data |
| lat_n | input | 1 | Address latch strobe, active low; starts a latency count |
| oe_n | input | 1 | Output enable, active low |
| wait_total | output | 3 | Stored total initial latency in cycles |
| first_valid | output | 1 | One-cycle pulse when the first word is due |
| rdy | output | 1 | Ready handshake; low while the first word is pending |

## Verification
Two functions can fall on the same clock edge: a configuration commit and a new address latch. The bench provokes this by driving the third command write and `lat_n` low in the same cycle. It checks that this count lasts the old number of cycles, and that the next latch counts the new value. A second overlap is a latch during a running count. There the bench checks that the ready rising edge is measured from the later latch and not from the first.

// File: rtl/blc_pkg.sv
// Shared types and key constants for the burst latency controller.
// Assumes write data is at least 8 bits wide and address low field 12 bits.
package blc_pkg;
    localparam int KEY_LO_W = 12;
    localparam logic [KEY_LO_W-1:0] KEY_ADDR_A = 12'h555;
    localparam logic [KEY_LO_W-1:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;
    localparam logic [7:0] ABORT_DATA = 8'hF0;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_KEY1  = 2'd1,
        SEQ_KEY2  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        TMR_READY = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_HOLD  = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/blc_cmd_seq.sv
// Command sequence decoder: tracks the two key writes and raises a one-cycle
// commit with the code taken from the third write's upper address bits.
// Assumes one write per cycle when wr_en is high; abort data has priority.
module blc_cmd_seq
    import blc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic [CODE_W-1:0] code
);
    localparam int CODE_LSB = KEY_LO_W;

    seq_state_t state_q, state_d;
    logic [KEY_LO_W-1:0] addr_lo;
    logic [7:0] data_lo;
    logic is_abort;

    assign addr_lo  = wr_addr[KEY_LO_W-1:0];
    assign data_lo  = wr_data[7:0];
    assign is_abort = (data_lo == ABORT_DATA);
    assign code     = wr_addr[CODE_LSB +: CODE_W];

    // Next state and commit decode for each accepted write.
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        if (wr_en) begin
            if (is_abort) begin
                state_d = SEQ_IDLE;
            end else begin
                unique case (state_q)
                    SEQ_IDLE:
                        state_d = (addr_lo == KEY_ADDR_A && data_lo == KEY_DATA_A)
                                  ? SEQ_KEY1 : SEQ_IDLE;
                    SEQ_KEY1:
                        state_d = (addr_lo == KEY_ADDR_B && data_lo == KEY_DATA_B)
                                  ? SEQ_KEY2 : SEQ_IDLE;
                    SEQ_KEY2: begin
                        state_d = SEQ_IDLE;
                        commit  = (addr_lo == KEY_ADDR_A);
                    end
                    default: state_d = SEQ_IDLE;
                endcase
            end
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/blc_wait_reg.sv
// Latency setting register: accepts a committed code only inside the legal
// range and otherwise keeps the stored value. Resets to the maximum latency.
module blc_wait_reg #(
    parameter int CODE_W  = 5,
    parameter int LAT_W   = 3,
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [CODE_W-1:0] code,
    output logic [LAT_W-1:0]  lat_total
);
    localparam logic [CODE_W-1:0] CODE_MIN = CODE_W'(MIN_LAT);
    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_LAT);

    logic in_range;
    assign in_range = (code >= CODE_MIN) && (code <= CODE_MAX);

    // Store a legal code on commit; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lat_total <= LAT_W'(MAX_LAT);
        else if (commit && in_range) lat_total <= LAT_W'(code);
    end
endmodule

// File: rtl/blc_lat_timer.sv
// Initial latency timer: restarts on every sampled latch, counts lat_total
// edges, then waits for output enable before raising ready with a pulse.
// Assumes lat_total >= 2 so that the reload value is nonzero.
module blc_lat_timer
    import blc_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_n,
    input  logic             oe_n,
    input  logic [LAT_W-1:0] lat_total,
    output logic             rdy,
    output logic             first_valid
);
    tmr_state_t st_q;
    logic [LAT_W-1:0] cnt_q;

    // Timer state, remaining count and first-data pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= TMR_READY;
            cnt_q       <= '0;
            first_valid <= 1'b0;
        end else begin
            first_valid <= 1'b0;
            if (!lat_n) begin
                st_q  <= TMR_COUNT;
                cnt_q <= lat_total - LAT_W'(1);
            end else begin
                unique case (st_q)
                    TMR_COUNT: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - LAT_W'(1);
                        end else if (!oe_n) begin
                            st_q        <= TMR_READY;
                            first_valid <= 1'b1;
                        end else begin
                            st_q <= TMR_HOLD;
                        end
                    end
                    TMR_HOLD: begin
                        if (!oe_n) begin
                            st_q        <= TMR_READY;
                            first_valid <= 1'b1;
                        end
                    end
                    default: st_q <= TMR_READY;
                endcase
            end
        end
    end

    // Ready is high only when no first word is pending.
    assign rdy = (st_q == TMR_READY);
endmodule

// File: rtl/burst_latency_ctrl.sv
// Top: protected latency configuration plus first-word ready handshake.
// Assumes ADDR_W = 12 + CODE_W and DATA_W >= 8.
module burst_latency_ctrl #(
    parameter int CODE_W  = 5,
    parameter int DATA_W  = 8,
    parameter int LAT_W   = 3,
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 7,
    parameter int ADDR_W  = 12 + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lat_n,
    input  logic              oe_n,
    output logic [LAT_W-1:0]  wait_total,
    output logic              first_valid,
    output logic              rdy
);
    logic              commit;
    logic [CODE_W-1:0] code;

    blc_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .code(code)
    );

    blc_wait_reg #(.CODE_W(CODE_W), .LAT_W(LAT_W),
                   .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) reg_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .code(code),
        .lat_total(wait_total)
    );

    blc_lat_timer #(.LAT_W(LAT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .lat_n(lat_n), .oe_n(oe_n),
        .lat_total(wait_total), .rdy(rdy), .first_valid(first_valid)
    );
endmodule

// File: rtl/blc_chk.sv
// Property checker for burst_latency_ctrl, attached with bind below.
module blc_chk #(
    parameter int LAT_W   = 3,
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             lat_n,
    input logic             oe_n,
    input logic [LAT_W-1:0] wait_total,
    input logic             first_valid,
    input logic             rdy
);
    // R3
    range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_total >= LAT_W'(MIN_LAT)) && (wait_total <= LAT_W'(MAX_LAT)));
    // R2
    change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wait_total) |-> $past(wr_en));
    // R6
    latch_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_n |=> !rdy);
    // R7
    rise_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(!oe_n));
    // R8
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |=> !first_valid);
    // R8
    pulse_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (rdy && $past(!rdy)));
    // R8
    rdy_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && lat_n) |=> rdy);
endmodule

bind burst_latency_ctrl blc_chk #(.LAT_W(LAT_W), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lat_n(lat_n), .oe_n(oe_n),
    .wait_total(wait_total), .first_valid(first_valid), .rdy(rdy)
);

// File: tb/burst_latency_ctrl_tb.sv
module burst_latency_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        lat_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [2:0]  wait_total;
    logic        first_valid;
    logic        rdy;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_latency_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lat_n(lat_n), .oe_n(oe_n),
        .wait_total(wait_total), .first_valid(first_valid), .rdy(rdy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int code);
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55);
        wr({code[4:0], 12'h555}, 8'h00);
    endtask

    // Latch, then count cycles until rdy rises; check pulse shape.
    task automatic measure(input string req, input int exp_lat);
        int k = 0;
        @(negedge clk); lat_n = 1'b0;
        @(negedge clk); lat_n = 1'b1;
        while (!rdy && k < 20) begin
            k++;
            @(negedge clk);
        end
        check(req, k, exp_lat);
        check("R8", int'(first_valid), 1);
        @(negedge clk);
        check("R8", int'(first_valid), 0);
        check("R8", int'(rdy), 1);
    endtask

    task automatic t_reset();
        check("R1", int'(wait_total), 7);
        check("R1", int'(rdy), 1);
        check("R1", int'(first_valid), 0);
    endtask

    task automatic t_program();
        measure("R6", 7);
        cfg(3); check("R2", int'(wait_total), 3); measure("R6", 3);
        cfg(2); check("R2", int'(wait_total), 2); measure("R6", 2);
        cfg(7); check("R2", int'(wait_total), 7);
        cfg(5); check("R2", int'(wait_total), 5);
    endtask

    task automatic t_range();
        cfg(0);  check("R3", int'(wait_total), 5);
        cfg(1);  check("R3", int'(wait_total), 5);
        cfg(8);  check("R3", int'(wait_total), 5);
        cfg(31); check("R3", int'(wait_total), 5);
        measure("R3", 5);
    endtask

    task automatic t_order();
        wr(17'h00555, 8'hAA); wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55); wr({5'd4, 12'h555}, 8'h00);
        check("R4", int'(wait_total), 5);
        wr(17'h002AA, 8'h55); wr(17'h00555, 8'hAA);
        wr({5'd4, 12'h555}, 8'h00);
        check("R4", int'(wait_total), 5);
        wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
        wr({5'd4, 12'h554}, 8'h00);
        check("R4", int'(wait_total), 5);
        wr(17'h00555, 8'hAB); wr(17'h002AA, 8'h55);
        wr({5'd4, 12'h555}, 8'h00);
        check("R4", int'(wait_total), 5);
    endtask

    task automatic t_abort();
        wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
        wr({5'd4, 12'h555}, 8'hF0);
        check("R5", int'(wait_total), 5);
        wr(17'h00555, 8'hAA); wr(17'h00000, 8'hF0);
        wr(17'h002AA, 8'h55); wr({5'd4, 12'h555}, 8'h00);
        check("R5", int'(wait_total), 5);
        cfg(4); check("R5", int'(wait_total), 4);
    endtask

    task automatic t_hold();
        @(negedge clk); oe_n = 1'b1; lat_n = 1'b0;
        @(negedge clk); lat_n = 1'b1;
        repeat (7) @(negedge clk);
        check("R7", int'(rdy), 0);
        check("R7", int'(first_valid), 0);
        oe_n = 1'b0;
        @(negedge clk);
        check("R7", int'(rdy), 1);
        check("R7", int'(first_valid), 1);
    endtask

    task automatic t_restart();
        @(negedge clk); lat_n = 1'b0;
        @(negedge clk); lat_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", int'(rdy), 0);
        measure("R9", 4);
    endtask

    task automatic t_same_edge();
        int k = 0;
        wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {5'd6, 12'h555}; wr_data = 8'h00; lat_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lat_n = 1'b1;
        check("R10", int'(wait_total), 6);
        while (!rdy && k < 20) begin
            k++;
            @(negedge clk);
        end
        check("R10", k, 4);
        measure("R10", 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_range();
        t_order();
        t_abort();
        t_hold();
        t_restart();
        t_same_edge();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule